// File: doc/BRIEF.md
# CPU Debug Front Panel

This block sits between the clock-enable generator of an 8-bit processor and the processor itself. It forwards the processor's clock enable while the machine runs. It withholds the enable when the machine is halted. A run/halt switch chooses between free running and halted operation. While halted, a step button lets exactly one instruction go through.

The block holds one breakpoint address and one watch address. An instruction fetch from the breakpoint address stops the processor before that instruction runs. A write to the watch address is allowed to complete, and the processor stops after it. Each event lights its own indicator.

Four hex digits on 7-segment displays show the live address bus, the breakpoint address or the watch address. The choice is made with a mode button. In the two edit views, a digit button picks a nibble and a set button increments it. The nibble being edited blinks at a rate set by a parameter.

Top module: `cpu_debug_panel`

## Requirements
- R1: While run is high and neither indicator is lit, cpu_en_o equals cpu_en_i in every cycle, except a cycle that a breakpoint withholds.
- R2: While run is low and no step is in progress, cpu_en_o stays low.
- R3: A step press while halted lets enables through, starting with the first enabled cycle. It withholds the next enabled cycle that has sync_i high, so the processor stops on the next instruction fetch. One instruction completes per press.
- R4: With the breakpoint armed and the machine running, an enabled cycle with sync_i high and addr_i equal to the breakpoint address is withheld, and bp_led_o lights. The processor then stays stopped. After a resume, the first instruction fetch is not matched, so the processor can leave the breakpoint.
- R5: With the watch point armed and the machine running, an enabled cycle with rnw_i low (write) and addr_i equal to the watch address passes, then wp_led_o lights and the processor stops.
- R6: After reset, both indicators are off, both points are disarmed, the live view is shown with digit 0 selected, and the run switch reads as halted until it has been synchronized.
- R7: A low-to-high change of the synchronized run switch clears both indicators.
- R8: The mode button steps through the views live address, breakpoint edit and watch edit, then back to live. Every change of view selects digit 0.
- R9: In an edit view, the digit button selects the next more significant digit and wraps from 3 to 0. The set button increments the selected nibble of the point being edited, with wrap, and arms that point. In the live view both buttons have no effect.
- R10: In an edit view, the selected digit is blanked (all segments off) in every other window of 2^BLINK_DIV cycles. All other digits stay steady.
- R11: Segment outputs are active low. In each 7-bit group, bit 0 is segment a and bit 6 is segment g. Group i of seg_o shows nibble i of the shown address, with group 0 the least significant. The lit-segment patterns for 0..F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71 (hex, active high).
- R12: A button acts once per press, after its level has been stable for DB_CYC cycles. A low pulse shorter than that has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_en_i | input | 1 | Processor clock enable from the generator |
| addr_i | input | ADDR_W | Processor address bus |
| rnw_i | input | 1 | High for read, low for write |
| sync_i | input | 1 | High during an opcode fetch cycle |
| run_i | input | 1 | Run (1) / halt (0) switch |
| step_n | input | 1 | Step button, active low |
| mode_n | input | 1 | View select button, active low |
| digit_n | input | 1 | Digit select button, active low |
| set_n | input | 1 | Digit increment button, active low |
| seg_o | output | ADDR_W/4*7 | Active-low segments, 7 per digit |
| bp_led_o | output | 1 | Breakpoint hit indicator |
| wp_led_o | output | 1 | Watch point hit indicator |
| cpu_en_o | output | 1 | Gated clock enable to the processor |

## Verification
The bench models a processor whose instructions take three enabled cycles, with a fetch on the first cycle and a write on the last. It advances the model only on passed enables, so its instruction counter shows the gating directly. The input enable toggles every cycle. This separates true pass-through from an output held high, and it shows whether steps stop on fetches rather than on raw cycles. All sixteen nibble values are swept on every digit to check the decoder and digit order. Edit sequences are chosen to cross the digit wrap. Breakpoint and watch addresses are placed so that a resume from the breakpoint must skip it and then stop after the write.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    typedef enum logic [1:0] {
        VIEW_LIVE  = 2'd0,
        VIEW_BRK   = 2'd1,
        VIEW_WATCH = 2'd2
    } view_e;

    localparam int BTN_STEP  = 0;
    localparam int BTN_MODE  = 1;
    localparam int BTN_DIGIT = 2;
    localparam int BTN_SET   = 3;
    localparam int BTN_COUNT = 4;

    function automatic view_e view_next(view_e v);
        case (v)
            VIEW_LIVE:  return VIEW_BRK;
            VIEW_BRK:   return VIEW_WATCH;
            default:    return VIEW_LIVE;
        endcase
    endfunction

endpackage

// File: rtl/btn_cond.sv
module btn_cond #(
    parameter int DB_CYC = 320000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    output logic press_o
);
    localparam int CNT_W = $clog2(DB_CYC + 1);

    typedef struct packed {
        logic [1:0]       sync;
        logic             stable;
        logic [CNT_W-1:0] cnt;
        logic             press;
    } btn_t;

    btn_t b_d, b_q;

    always_comb begin
        b_d       = b_q;
        b_d.sync  = {b_q.sync[0], btn_n};
        b_d.press = 1'b0;
        if (b_q.sync[1] != b_q.stable) begin
            if (b_q.cnt == CNT_W'(DB_CYC - 1)) begin
                b_d.stable = b_q.sync[1];
                b_d.cnt    = '0;
                b_d.press  = !b_q.sync[1];
            end else begin
                b_d.cnt = b_q.cnt + 1'b1;
            end
        end else begin
            b_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '{sync: 2'b11, stable: 1'b1, cnt: '0, press: 1'b0};
        end else begin
            b_q <= b_d;
        end
    end

    assign press_o = b_q.press;

    AST_PRESS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        press_o |=> !press_o); // R12

endmodule

// File: rtl/seg7_hex.sv
module seg7_hex (
    input  logic [3:0] nib_i,
    input  logic       blank_i,
    output logic [6:0] seg_n_o
);
    logic [6:0] lit;

    always_comb begin
        case (nib_i)
            4'h0: lit = 7'h3F;
            4'h1: lit = 7'h06;
            4'h2: lit = 7'h5B;
            4'h3: lit = 7'h4F;
            4'h4: lit = 7'h66;
            4'h5: lit = 7'h6D;
            4'h6: lit = 7'h7D;
            4'h7: lit = 7'h07;
            4'h8: lit = 7'h7F;
            4'h9: lit = 7'h6F;
            4'hA: lit = 7'h77;
            4'hB: lit = 7'h7C;
            4'hC: lit = 7'h39;
            4'hD: lit = 7'h5E;
            4'hE: lit = 7'h79;
            default: lit = 7'h71;
        endcase
        seg_n_o = blank_i ? 7'h7F : ~lit;
    end

endmodule

// File: rtl/cpu_debug_panel.sv
module cpu_debug_panel
    import dbg_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DB_CYC    = 320000,
    parameter int BLINK_DIV = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_en_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    rnw_i,
    input  logic                    sync_i,
    input  logic                    run_i,
    input  logic                    step_n,
    input  logic                    mode_n,
    input  logic                    digit_n,
    input  logic                    set_n,
    output logic [ADDR_W/4*7-1:0]   seg_o,
    output logic                    bp_led_o,
    output logic                    wp_led_o,
    output logic                    cpu_en_o
);
    localparam int NDIG  = ADDR_W / 4;
    localparam int SEL_W = (NDIG > 1) ? $clog2(NDIG) : 1;

    typedef struct packed {
        logic [1:0]           run_sync;
        logic                 run_prev;
        view_e                view;
        logic [SEL_W-1:0]     sel;
        logic [ADDR_W-1:0]    bp_addr;
        logic [ADDR_W-1:0]    wp_addr;
        logic                 bp_en;
        logic                 wp_en;
        logic                 bp_led;
        logic                 wp_led;
        logic                 step_act;
        logic                 step_first;
        logic                 skip;
        logic [BLINK_DIV-1:0] blink_cnt;
        logic                 blink;
    } state_t;

    state_t s_d, s_q;

    // Button conditioning, one instance per button
    logic [BTN_COUNT-1:0] btn_n_vec;
    logic [BTN_COUNT-1:0] press;

    assign btn_n_vec = {set_n, digit_n, mode_n, step_n};

    for (genvar b = 0; b < BTN_COUNT; b++) begin : g_btn
        btn_cond #(.DB_CYC(DB_CYC)) u_btn (
            .clk     (clk),
            .rst_n   (rst_n),
            .btn_n   (btn_n_vec[b]),
            .press_o (press[b])
        );
    end

    // Gating decisions
    logic run_s, hold, bp_hit, wp_hit, step_stop, en;

    always_comb begin
        run_s     = s_q.run_sync[1];
        hold      = !run_s || s_q.bp_led || s_q.wp_led;
        bp_hit    = s_q.bp_en && !hold && !s_q.skip && cpu_en_i && sync_i
                    && (addr_i == s_q.bp_addr);
        wp_hit    = s_q.wp_en && !hold && cpu_en_i && !rnw_i
                    && (addr_i == s_q.wp_addr);
        step_stop = s_q.step_act && !s_q.step_first && cpu_en_i && sync_i;
        if (hold) begin
            en = s_q.step_act && cpu_en_i && !step_stop;
        end else begin
            en = cpu_en_i && !bp_hit;
        end
    end

    // Next-state logic
    always_comb begin
        s_d          = s_q;
        s_d.run_sync = {s_q.run_sync[0], run_i};
        s_d.run_prev = run_s;

        if (hold) begin
            s_d.skip = 1'b1;
        end else if (en && sync_i) begin
            s_d.skip = 1'b0;
        end

        if (run_s && !s_q.run_prev) begin
            s_d.bp_led = 1'b0;
            s_d.wp_led = 1'b0;
        end
        if (bp_hit) begin
            s_d.bp_led = 1'b1;
        end
        if (wp_hit) begin
            s_d.wp_led = 1'b1;
        end

        if (!hold) begin
            s_d.step_act = 1'b0;
        end else if (s_q.step_act) begin
            if (cpu_en_i) begin
                s_d.step_first = 1'b0;
            end
            if (step_stop) begin
                s_d.step_act = 1'b0;
            end
        end else if (press[BTN_STEP]) begin
            s_d.step_act   = 1'b1;
            s_d.step_first = 1'b1;
        end

        s_d.blink_cnt = s_q.blink_cnt + 1'b1;
        if (&s_q.blink_cnt) begin
            s_d.blink = !s_q.blink;
        end

        if (press[BTN_MODE]) begin
            s_d.view = view_next(s_q.view);
            s_d.sel  = '0;
        end else if (s_q.view != VIEW_LIVE) begin
            if (press[BTN_DIGIT]) begin
                s_d.sel = (s_q.sel == SEL_W'(NDIG - 1)) ? '0 : s_q.sel + 1'b1;
            end
            if (press[BTN_SET]) begin
                for (int i = 0; i < NDIG; i++) begin
                    if (s_q.sel == SEL_W'(i)) begin
                        if (s_q.view == VIEW_BRK) begin
                            s_d.bp_addr[i*4 +: 4] = s_q.bp_addr[i*4 +: 4] + 4'd1;
                        end else begin
                            s_d.wp_addr[i*4 +: 4] = s_q.wp_addr[i*4 +: 4] + 4'd1;
                        end
                    end
                end
                if (s_q.view == VIEW_BRK) begin
                    s_d.bp_en = 1'b1;
                end else begin
                    s_d.wp_en = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{run_sync: 2'b00, run_prev: 1'b0, view: VIEW_LIVE,
                     sel: '0, bp_addr: '0, wp_addr: '0, bp_en: 1'b0,
                     wp_en: 1'b0, bp_led: 1'b0, wp_led: 1'b0,
                     step_act: 1'b0, step_first: 1'b0, skip: 1'b1,
                     blink_cnt: '0, blink: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cpu_en_o = en;
    assign bp_led_o = s_q.bp_led;
    assign wp_led_o = s_q.wp_led;

    // Display
    logic [ADDR_W-1:0] shown;

    always_comb begin
        case (s_q.view)
            VIEW_BRK:   shown = s_q.bp_addr;
            VIEW_WATCH: shown = s_q.wp_addr;
            default:    shown = addr_i;
        endcase
    end

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        logic blank;
        assign blank = (s_q.view != VIEW_LIVE) && (s_q.sel == SEL_W'(g)) && s_q.blink;
        seg7_hex u_hex (
            .nib_i   (shown[g*4 +: 4]),
            .blank_i (blank),
            .seg_n_o (seg_o[g*7 +: 7])
        );
    end

    // Assertions
    AST_EN_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en_o |-> cpu_en_i); // R1

    AST_HALT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_s && !s_q.step_act) |-> !cpu_en_o); // R2

    AST_STEP_ONE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && cpu_en_o && sync_i) |-> s_q.step_first); // R3

    AST_BP_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en_i && sync_i && s_q.bp_en && !hold && !s_q.skip
         && addr_i == s_q.bp_addr) |=> bp_led_o); // R4

    AST_WP_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en_i && !rnw_i && s_q.wp_en && !hold
         && addr_i == s_q.wp_addr) |=> wp_led_o); // R5

    AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_s) |=> !bp_led_o); // R7

endmodule

// File: tb/cpu_debug_panel_test.sv
module cpu_debug_panel_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  ADDR_W = 16;
    localparam int  NDIG   = ADDR_W / 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic step_n = 1'b1, mode_n = 1'b1, digit_n = 1'b1, set_n = 1'b1;
    logic en_in = 1'b0;
    logic en_flag = 1'b0;
    logic use_ovr = 1'b0;
    logic [ADDR_W-1:0] ovr = '0;
    int k = 0;

    logic [ADDR_W-1:0]   addr_w;
    logic                sync_w, rnw_w;
    logic [NDIG*7-1:0]   seg;
    logic                bp_led, wp_led, cpu_en_o;

    int total = 0;
    int bad = 0;

    assign addr_w = use_ovr ? ovr : (16'h1000 + k[15:0]);
    assign sync_w = (k % 3) == 0;
    assign rnw_w  = (k % 3) != 2;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cpu_debug_panel #(.ADDR_W(ADDR_W), .DB_CYC(4), .BLINK_DIV(3)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_en_i (en_in),
        .addr_i   (addr_w),
        .rnw_i    (rnw_w),
        .sync_i   (sync_w),
        .run_i    (run),
        .step_n   (step_n),
        .mode_n   (mode_n),
        .digit_n  (digit_n),
        .set_n    (set_n),
        .seg_o    (seg),
        .bp_led_o (bp_led),
        .wp_led_o (wp_led),
        .cpu_en_o (cpu_en_o)
    );

    function automatic logic [6:0] pat(int n);
        case (n)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
            4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
            8: return 7'h7F;  9: return 7'h6F;  10: return 7'h77; 11: return 7'h7C;
            12: return 7'h39; 13: return 7'h5E; 14: return 7'h79; default: return 7'h71;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Processor model advances on each enable passed at the previous edge
    task automatic tick();
        @(negedge clk);
        if (en_flag) k = k + 1;
        en_in = ~en_in;
        #1;
        en_flag = cpu_en_o;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic press(input int which);
        case (which)
            0: step_n = 1'b0;
            1: mode_n = 1'b0;
            2: digit_n = 1'b0;
            default: set_n = 1'b0;
        endcase
        ticks(12);
        step_n = 1'b1; mode_n = 1'b1; digit_n = 1'b1; set_n = 1'b1;
        ticks(12);
    endtask

    task automatic presses(input int which, input int n);
        for (int i = 0; i < n; i++) press(which);
    endtask

    task automatic check_digit(input int idx, input int nib, input bit selected,
                               input string req);
        int match = 0;
        int blank = 0;
        for (int i = 0; i < 16; i++) begin
            tick();
            if (seg[idx*7 +: 7] == ~pat(nib)) match++;
            else if (seg[idx*7 +: 7] == 7'h7F) blank++;
        end
        if (selected) chk(match == 8 && blank == 8, req, match, 8);
        else          chk(match == 16, req, match, 16);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        en_flag = 1'b0;
        ticks(3);
        rst_n = 1'b1;
        ticks(2);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int k0;
        int errs;
        do_reset();

        // R6: reset state
        chk(bp_led == 0 && wp_led == 0, "R6 leds after reset", {bp_led, wp_led}, 0);
        chk(cpu_en_o == 0, "R6 halted after reset", cpu_en_o, 0);

        // R11: decoder sweep on every digit, live view
        use_ovr = 1'b1;
        errs = 0;
        for (int n = 0; n < 16; n++) begin
            ovr = {4{n[3:0]}};
            tick();
            for (int d = 0; d < NDIG; d++)
                if (seg[d*7 +: 7] != ~pat(n)) errs++;
        end
        chk(errs == 0, "R11 segment sweep", errs, 0);
        ovr = 16'h1234;
        tick();
        chk(seg[0 +: 7] == ~pat(4) && seg[21 +: 7] == ~pat(1), "R11 digit order",
            seg[0 +: 7], ~pat(4));
        use_ovr = 1'b0;

        // R1: pass-through while running
        run = 1'b1;
        ticks(5);
        errs = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (en_flag != en_in) errs++;
        end
        chk(errs == 0, "R1 pass-through", errs, 0);
        chk(k > 15, "R1 model advanced", k, 20);

        // R2: halted freezes the model
        run = 1'b0;
        ticks(5);
        k0 = k;
        ticks(20);
        chk(k == k0, "R2 halted", k, k0);

        // R3: steps stop on instruction fetches
        press(0);
        chk(k > k0 && k % 3 == 0, "R3 step to fetch", k, k0 + 3 - k0 % 3);
        k0 = k;
        press(0);
        chk(k == k0 + 3, "R3 single instruction", k, k0 + 3);
        ticks(10);
        chk(k == k0 + 3, "R3 holds between steps", k, k0 + 3);

        // Edit breakpoint to 0x1009 (R8, R9, R10)
        k = 0;
        en_flag = 1'b0;
        press(1);
        check_digit(0, 0, 1'b1, "R10 selected digit blinks");
        check_digit(1, 0, 1'b0, "R10 other digit steady");
        presses(2, 3);
        press(3);
        press(2);
        presses(3, 9);
        check_digit(0, 9, 1'b1, "R9 digit wrap and set");
        check_digit(3, 1, 1'b0, "R9 top digit set");
        check_digit(2, 0, 1'b0, "R9 untouched digit");

        // Watch address 0x100E; view change reselects digit 0 (R8)
        press(1);
        presses(3, 14);
        presses(2, 3);
        press(3);
        presses(2, 1);
        check_digit(0, 14, 1'b1, "R8 watch view digit0");
        check_digit(3, 1, 1'b0, "R8 watch view digit3");
        press(1);
        use_ovr = 1'b1;
        ovr = 16'hABCD;
        check_digit(0, 13, 1'b0, "R8 back to live");
        use_ovr = 1'b0;

        // R4: breakpoint at fetch 9
        run = 1'b1;
        ticks(60);
        chk(k == 9, "R4 stopped at breakpoint", k, 9);
        chk(bp_led == 1 && wp_led == 0, "R4 bp led", {bp_led, wp_led}, 2);

        // R7 + R5: resume clears, skips breakpoint, stops after write at 14
        run = 1'b0;
        ticks(6);
        run = 1'b1;
        ticks(4);
        chk(bp_led == 0, "R7 resume clears", bp_led, 0);
        ticks(60);
        chk(k == 15, "R5 stopped after write", k, 15);
        chk(wp_led == 1 && bp_led == 0, "R5 wp led", {bp_led, wp_led}, 1);

        // R3: step while held by indicator
        press(0);
        chk(k == 18, "R3 step from watch stop", k, 18);
        chk(wp_led == 1, "R3 indicator kept", wp_led, 1);

        // R12: short glitch ignored
        mode_n = 1'b0;
        ticks(2);
        mode_n = 1'b1;
        ticks(12);
        use_ovr = 1'b1;
        ovr = 16'hABCD;
        check_digit(0, 13, 1'b0, "R12 glitch ignored");

        // R9: set in live view does nothing
        press(3);
        press(1);
        check_digit(0, 9, 1'b1, "R9 set ignored in live");
        press(1);
        press(1);
        use_ovr = 1'b0;

        // R6: after reset both points disarmed
        run = 1'b0;
        do_reset();
        k = 0;
        run = 1'b1;
        ticks(80);
        chk(k > 20 && bp_led == 0 && wp_led == 0, "R6 points disarmed", k, 30);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule